// File: doc/BRIEF.md
# Paged Asynchronous Byte SRAM Model

A clocked, synthesizable stand-in for a byte-wide asynchronous static RAM. It is meant for checking a memory controller. At every rising edge of the model clock it samples the pins a controller would drive: an active-low select, an active-high select, a write strobe, an output enable, the address and the write data. From these it decides whether the part is in standby, writing, reading or selected with its output switched off. Analog behaviour and nanosecond timing are not modelled.

Storage is split into pages of 16 bytes. The low four address bits pick the byte and the upper bits pick the page. The model remembers which page the last read opened. Each read that falls in that open page, with the part kept selected, is reported as a page-mode hit. A controller under test can therefore be scored on whether it walks a page without reopening it. Only a reduced number of pages is physically stored. Higher page numbers wrap onto the stored ones, while the page tracking still compares the full page number.

The tri-state bus is split into a data output and a drive-enable output. All outputs are registered: they reflect the pins sampled at the preceding clock edge.

Top module: `sram_page_model`

## Requirements
- R1: While rst_ni is low and after it rises, data_oe_o, data_o and page_hit_o are 0, and no page is open, so the first read after reset gives no page hit.
- R2: The part is selected only when sel_n_i is 0 and sel_i is 1. In a cycle where it is not selected, data_oe_o and data_o are 0 after the next edge, whatever wr_n_i and rd_n_i are.
- R3: In standby, addr_i, wr_n_i, rd_n_i and wdata_i have no effect: driving wr_n_i low while deselected does not change any stored byte.
- R4: A selected cycle with wr_n_i at 0 is a write cycle. rd_n_i is ignored in it, and data_oe_o is 0 after the next edge.
- R5: A write is committed when wr_n_i returns to 1 or the part is deselected, whichever comes first. It stores the address and data sampled in the last write cycle. A read in the commit cycle already returns the new byte.
- R6: A selected cycle with wr_n_i at 1 and rd_n_i at 0 is a read: after the next edge data_oe_o is 1 and data_o holds the stored byte at addr_i.
- R7: A selected cycle with wr_n_i and rd_n_i both at 1 leaves data_oe_o at 0 and keeps the open page open.
- R8: A read whose address bits above bit 3 equal the open page asserts page_hit_o for exactly that one output cycle. Every read opens its own page.
- R9: A standby cycle closes the page. A read to a different page is not a hit, and it opens that new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_n_i | input | 1 | Select, active low |
| sel_i | input | 1 | Select, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| rd_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W (18) | Byte address; bits 3:0 word, upper bits page |
| wdata_i | input | DATA_W (8) | Data presented by the controller |
| data_o | output | DATA_W (8) | Read data, 0 when not driven |
| data_oe_o | output | 1 | 1 when the model drives the bus |
| page_hit_o | output | 1 | Read landed in the open page |

## Verification
The bench targets writes whose strobe stays low across an address change. A model that committed every write cycle would also store the first address. It drives a read straight after the end of a write; without forwarding, that read returns the old byte. Strobes toggled while deselected must leave memory untouched, and a design that honoured them would corrupt it. Page tracking is exercised across an output-disabled cycle, which must keep the page, and across standby and a page change, which must not give a hit. A tracker that cleared on every non-read, or never cleared, would get page_hit_o wrong in one of these.

// File: rtl/sram_page_pkg.sv
package sram_page_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_WRITE   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_IDLE    = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_page_pkg::*;
(
  input  logic      sel_n_i,
  input  logic      sel_i,
  input  logic      wr_n_i,
  input  logic      rd_n_i,
  output acc_mode_e mode_o
);
  always_comb begin
    if (sel_n_i || !sel_i)  mode_o = MODE_STANDBY;
    else if (!wr_n_i)       mode_o = MODE_WRITE;   // write overrides output enable
    else if (!rd_n_i)       mode_o = MODE_READ;
    else                    mode_o = MODE_IDLE;
  end
endmodule

// File: rtl/sram_page_track.sv
module sram_page_track
  import sram_page_pkg::*;
#(
  parameter int PAGE_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_mode_e         mode_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              hit_o
);
  logic              open_vld_q;
  logic [PAGE_W-1:0] open_page_q;

  assign hit_o = (mode_i == MODE_READ) && open_vld_q && (open_page_q == page_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_vld_q  <= 1'b0;
      open_page_q <= '0;
    end else if (mode_i == MODE_STANDBY) begin
      open_vld_q  <= 1'b0;
    end else if (mode_i == MODE_READ) begin
      open_vld_q  <= 1'b1;
      open_page_q <= page_i;
    end
  end
endmodule

// File: rtl/sram_byte_store.sv
module sram_byte_store
  import sram_page_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_mode_e         mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              pend_q;
  logic [IDX_W-1:0]  pidx_q;
  logic [DATA_W-1:0] pdata_q;
  logic              commit;

  // strobe released or part deselected
  assign commit = pend_q && (mode_i != MODE_WRITE);

  always_ff @(posedge clk_i) begin
    if (commit) mem_q[pidx_q] <= pdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pidx_q  <= '0;
      pdata_q <= '0;
    end else begin
      pend_q <= (mode_i == MODE_WRITE);
      if (mode_i == MODE_WRITE) begin
        pidx_q  <= idx_i;
        pdata_q <= wdata_i;
      end
    end
  end

  assign rdata_o = (commit && (pidx_q == idx_i)) ? pdata_q : mem_q[idx_i];
endmodule

// File: rtl/sram_page_model.sv
module sram_page_model
  import sram_page_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int WORD_BITS   = 4,
  parameter int STORE_PAGES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_n_i,
  input  logic              sel_i,
  input  logic              wr_n_i,
  input  logic              rd_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              page_hit_o
);
  localparam int PAGE_W = ADDR_W - WORD_BITS;
  localparam int DEPTH  = STORE_PAGES * (1 << WORD_BITS);
  localparam int IDX_W  = $clog2(DEPTH);

  acc_mode_e         mode;
  logic              hit;
  logic [DATA_W-1:0] rdata;

  sram_mode_decode u_dec (
    .sel_n_i (sel_n_i),
    .sel_i   (sel_i),
    .wr_n_i  (wr_n_i),
    .rd_n_i  (rd_n_i),
    .mode_o  (mode)
  );

  sram_page_track #(.PAGE_W(PAGE_W)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .page_i (addr_i[ADDR_W-1:WORD_BITS]),
    .hit_o  (hit)
  );

  sram_byte_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .idx_i   (addr_i[IDX_W-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o     <= '0;
      data_oe_o  <= 1'b0;
      page_hit_o <= 1'b0;
    end else begin
      data_oe_o  <= (mode == MODE_READ);
      data_o     <= (mode == MODE_READ) ? rdata : '0;
      page_hit_o <= hit;
    end
  end
endmodule

// File: rtl/sram_page_checker.sv
module sram_page_checker #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_n_i,
  input logic              sel_i,
  input logic              wr_n_i,
  input logic              rd_n_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              page_hit_o
);
  logic on_c, rd_c;
  assign on_c = !sel_n_i && sel_i;
  assign rd_c = on_c && wr_n_i && !rd_n_i;

  AST_STANDBY_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_c |=> (!data_oe_o && data_o == '0)); // R2
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_c && !wr_n_i) |=> !data_oe_o); // R4
  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_c |=> data_oe_o); // R6
  AST_IDLE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_c && wr_n_i && rd_n_i) |=> !data_oe_o); // R7
  AST_HIT_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_hit_o |-> data_oe_o); // R8
  AST_NO_HIT_AFTER_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_c ##1 rd_c) |=> !page_hit_o); // R9
endmodule

bind sram_page_model sram_page_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_n_i    (sel_n_i),
  .sel_i      (sel_i),
  .wr_n_i     (wr_n_i),
  .rd_n_i     (rd_n_i),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .page_hit_o (page_hit_o)
);

// File: tb/sram_page_model_bench.sv
module sram_page_model_bench;
  localparam int AW    = 18;
  localparam int DW    = 8;
  localparam int DEPTH = 64 * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n = 1'b1, sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] data;
  logic          data_oe, page_hit;

  int n_run = 0, n_fail = 0;

  // reference state
  int  ref_mem [int];
  bit  pend = 0;
  int  p_idx = 0, p_dat = 0;
  bit  pg_vld = 0;
  int  pg_num = 0;

  always #10 clk = ~clk;

  sram_page_model u_sram_page_model (
    .clk_i(clk), .rst_ni(rst_n), .sel_n_i(sel_n), .sel_i(sel),
    .wr_n_i(wr_n), .rd_n_i(rd_n), .addr_i(addr), .wdata_i(wdata),
    .data_o(data), .data_oe_o(data_oe), .page_hit_o(page_hit)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit s_n, input bit s, input bit w_n,
                      input bit r_n, input int a, input int d);
    bit on, wr, rd, commit, known;
    int idx, exp_d;
    @(negedge clk);
    sel_n = s_n; sel = s; wr_n = w_n; rd_n = r_n; addr = AW'(a); wdata = DW'(d);
    on = !s_n && s; wr = on && !w_n; rd = on && w_n && !r_n;
    idx = a % DEPTH;
    commit = pend && !wr;
    known = 1; exp_d = 0;
    if (rd) begin
      if (commit && p_idx == idx) exp_d = p_dat;
      else if (ref_mem.exists(idx)) exp_d = ref_mem[idx];
      else known = 0;
    end
    @(posedge clk); #1;
    chk(tag, "data_oe", int'(data_oe), int'(rd));
    chk(tag, "page_hit", int'(page_hit), int'(rd && pg_vld && (a >> 4) == pg_num));
    if (known) chk(tag, "data", int'(data), exp_d);
    if (commit) ref_mem[p_idx] = p_dat;
    pend = wr;
    if (wr) begin p_idx = idx; p_dat = d; end
    if (!on) pg_vld = 0;
    else if (rd) begin pg_vld = 1; pg_num = a >> 4; end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "data_oe in reset", int'(data_oe), 0);
    chk("R1", "data in reset", int'(data), 0);
    chk("R1", "page_hit in reset", int'(page_hit), 0);
    @(negedge clk); rst_n = 1'b1;

    // R4: writes, some with output enable low too
    for (int i = 0; i < 16; i++) begin
      step("R4", 0, 1, 0, i % 2, i, 8'h30 + i);
      step("R4", 0, 1, 1, 1, i, 0);
    end
    for (int i = 0; i < 4; i++) begin
      step("R4", 0, 1, 0, 1, 16 + i, 8'hA0 + i);
      step("R4", 0, 1, 1, 1, 0, 0);
    end
    // R5: strobe held across address change; only last stored
    step("R5", 0, 1, 0, 1, 20, 8'h11);
    step("R5", 0, 1, 0, 1, 21, 8'h22);
    step("R5", 0, 1, 1, 1, 0, 0);
    // R5: write ended by deselect
    step("R5", 0, 1, 0, 1, 22, 8'h5C);
    step("R5", 1, 1, 0, 1, 22, 8'hFF);
    // R1: first read since reset opens a page, no hit
    step("R1", 0, 1, 1, 0, 3, 0);
    step("R8", 0, 1, 1, 0, 5, 0);
    step("R8", 0, 1, 1, 0, 12, 0);
    step("R7", 0, 1, 1, 1, 9, 0);
    step("R7", 0, 1, 1, 0, 1, 0);
    step("R5", 0, 1, 1, 0, 20, 0);
    step("R5", 0, 1, 1, 0, 21, 0);
    step("R5", 0, 1, 1, 0, 22, 0);
    // R9: page change
    step("R9", 0, 1, 1, 0, 17, 0);
    step("R9", 0, 1, 1, 0, 18, 0);
    // R5: read in commit cycle sees new data
    step("R5", 0, 1, 0, 1, 7, 8'hE7);
    step("R5", 0, 1, 1, 0, 7, 0);
    // R2/R3: deselect by either pin with strobes active
    step("R2", 1, 1, 1, 0, 4, 0);
    step("R3", 1, 1, 0, 0, 4, 8'h99);
    step("R3", 0, 0, 0, 1, 5, 8'h98);
    step("R2", 0, 0, 1, 0, 6, 0);
    step("R3", 1, 0, 0, 0, 6, 8'h97);
    // R9: read after standby, same page, no hit; then hits
    step("R9", 0, 1, 1, 0, 4, 0);
    step("R3", 0, 1, 1, 0, 5, 0);
    step("R3", 0, 1, 1, 0, 6, 0);
    // R9: upper page bits alias storage but differ in page number
    step("R9", 0, 1, 1, 0, 4 + DEPTH, 0);
    step("R8", 0, 1, 1, 0, 5 + DEPTH, 0);
    step("R2", 1, 0, 1, 1, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule